// File: doc/BRIEF.md
# Programmable asynchronous serial frame transmitter

This block turns characters held in an upstream transmit FIFO into asynchronous serial frames on a single output line. The line is low for one start bit. The data bits follow, least significant first, and a parity bit comes next if parity is on. The frame closes with one or two high stop bits. Software sets the character length (5 to 8 bits), whether parity is present, its sense, and the stop-bit count through static format inputs. The block latches these inputs when each character starts, so a frame is never mixed between two formats.

Bit timing comes from an external baud tick that pulses at sixteen times the bit rate. The block counts sixteen ticks per bit. It reads the FIFO through a show-ahead interface: it looks at the empty flag and the head data and pulses a pop strobe. It pops only between characters. A global enable and a transmit enable gate the start of new characters only. When either is cleared in the middle of a frame, the frame still completes and the line then rests high.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame starts with one low start bit, followed by the data bits with bit 0 of the popped character first.
- R2: The number of data bits is 5 plus the length code (code 0 = 5 bits, code 3 = 8 bits); character bits above that count are never sent.
- R3: A parity bit follows the last data bit only when parity is enabled; otherwise the first stop bit follows the last data bit directly.
- R4: With odd-select low the parity bit makes the count of ones over the sent data bits plus parity even; with odd-select high it makes that count odd.
- R5: The frame ends with one stop bit when two-stop is low and two stop bits when it is high, all driven high.
- R6: Every bit lasts exactly 16 baud ticks. With the tick held high and the FIFO kept non-empty, consecutive start bits begin 16*N+1 clock cycles apart, where N is the frame length in bits.
- R7: After reset, and whenever no character is in flight, the line is high, busy is low and no pop is issued while the FIFO is empty.
- R8: Pop is a single-cycle pulse. It is issued only while idle with the FIFO not empty, and exactly once per transmitted character.
- R9: A new character starts only when both the global enable and the transmit enable are high. Clearing either one during a frame lets that frame finish unchanged and then blocks further pops.
- R10: Format inputs that change while a frame is in flight have no effect on that frame.
- R11: Busy rises in the cycle after the pop, together with the start bit, and stays high until the last stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Global enable |
| tx_en_i | input | 1 | Transmit enable |
| len_code_i | input | 2 | Character length code, data bits = 5 + code |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Parity sense, 1 = odd |
| two_stop_i | input | 1 | 1 = two stop bits |
| tick_i | input | 1 | Baud tick at 16x the bit rate |
| fifo_empty_i | input | 1 | Transmit FIFO empty flag |
| fifo_data_i | input | 8 | FIFO head character (show-ahead) |
| fifo_pop_o | output | 1 | FIFO pop strobe |
| line_o | output | 1 | Serial output line |
| busy_o | output | 1 | A frame is in flight |

## Verification
The bench runs every combination of length code, parity mode and stop count on two back-to-back characters. Each character has bits set above the configured length, so a design that sent the wrong number of bits, leaked high bits, put parity in the wrong place or computed it over the full byte would show a wrong sampled bit. A wrong start-to-start interval exposes an off-by-one in the sixteen-tick bit counter or an extra or missing stop bit. Further tests clear each enable in the middle of a frame and change the format mid-frame. A design that aborted the frame, took the new format, or kept popping would show a truncated frame, a changed field or an extra pop. A slower tick checks that bit timing follows the tick and not the clock.

// File: rtl/uart_tx_pkg.sv
// Shared types for the frame transmitter: controller state and format word.
// Assumes a two-bit length code covering 5..8 data bits.
package uart_tx_pkg;

    localparam int LEN_CODE_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic [LEN_CODE_W-1:0] len_code;
        logic                  par_en;
        logic                  par_odd;
        logic                  two_stop;
    } tx_fmt_t;

endpackage

// File: rtl/uart_tx_tickdiv.sv
// Counts baud ticks within one bit period and flags the tick that ends the bit.
// Assumes clear_i is pulsed when a frame starts so every bit spans OVS ticks.
module uart_tx_tickdiv #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic bit_done_o
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [CW-1:0] cnt_q;

    // Tick position inside the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    // Bit boundary on the final tick of the period.
    always_comb bit_done_o = tick_i && (cnt_q == LAST);

endmodule

// File: rtl/uart_tx_shifter.sv
// Holds the character being sent and shifts it out LSB first; computes the
// parity bit at load time over only the configured number of data bits.
// Assumes nbits_i and par_odd_i are valid in the load cycle.
module uart_tx_shifter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  nbits_i,
    input  logic              par_odd_i,
    input  logic              shift_i,
    output logic              lsb_o,
    output logic              parity_o
);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] sreg_q;
    logic              par_q;

    // Mask of the bit positions that belong to the character.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (CNT_W'(g) < nbits_i);
    end

    // Load on frame start, shift right on each data-bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            par_q  <= 1'b0;
        end else if (load_i) begin
            sreg_q <= data_i;
            par_q  <= (^(data_i & mask)) ^ par_odd_i;
        end else if (shift_i) begin
            sreg_q <= {1'b0, sreg_q[DATA_W-1:1]};
        end
    end

    // Current data bit and latched parity.
    always_comb begin
        lsb_o    = sreg_q[0];
        parity_o = par_q;
    end

endmodule

// File: rtl/uart_tx_ctrl.sv
// Frame sequencer: decides when to pop a character, latches the format for
// the frame and walks start, data, parity and stop bits on bit boundaries.
// Assumes start_ok_i already combines both enables with FIFO not empty.
module uart_tx_ctrl
    import uart_tx_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int MIN_BITS = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_ok_i,
    input  logic      bit_done_i,
    input  tx_fmt_t   fmt_i,
    output tx_state_e state_o,
    output logic      pop_o,
    output logic      shift_o
);
    tx_state_e        state_q;
    tx_fmt_t          fmt_q;
    logic [CNT_W-1:0] bit_idx_q;
    logic             stop_idx_q;
    logic [CNT_W-1:0] nbits;
    logic             last_data;

    // Data-bit count of the latched format and last-bit detection.
    always_comb begin
        nbits     = CNT_W'(MIN_BITS) + CNT_W'(fmt_q.len_code);
        last_data = (bit_idx_q == nbits - CNT_W'(1));
        pop_o     = (state_q == ST_IDLE) && start_ok_i;
        shift_o   = (state_q == ST_DATA) && bit_done_i;
        state_o   = state_q;
    end

    // Frame state, bit index, stop index and latched format.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fmt_q      <= '0;
            bit_idx_q  <= '0;
            stop_idx_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_ok_i) begin
                        state_q <= ST_START;
                        fmt_q   <= fmt_i;
                    end
                end
                ST_START: begin
                    if (bit_done_i) begin
                        state_q   <= ST_DATA;
                        bit_idx_q <= '0;
                    end
                end
                ST_DATA: begin
                    if (bit_done_i) begin
                        if (last_data) begin
                            state_q    <= fmt_q.par_en ? ST_PARITY : ST_STOP;
                            stop_idx_q <= 1'b0;
                        end else begin
                            bit_idx_q <= bit_idx_q + CNT_W'(1);
                        end
                    end
                end
                ST_PARITY: begin
                    if (bit_done_i) begin
                        state_q    <= ST_STOP;
                        stop_idx_q <= 1'b0;
                    end
                end
                ST_STOP: begin
                    if (bit_done_i) begin
                        if (fmt_q.two_stop && !stop_idx_q) begin
                            stop_idx_q <= 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_frame_tx.sv
// Top of the frame transmitter: joins the sequencer, tick divider and shifter
// and drives the line from the current frame state.
// Assumes a show-ahead FIFO whose head data is valid while empty is low.
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5,
    parameter int OVS      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  tx_en_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  par_en_i,
    input  logic                  par_odd_i,
    input  logic                  two_stop_i,
    input  logic                  tick_i,
    input  logic                  fifo_empty_i,
    input  logic [DATA_W-1:0]     fifo_data_i,
    output logic                  fifo_pop_o,
    output logic                  line_o,
    output logic                  busy_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    tx_fmt_t          fmt_in;
    tx_state_e        state;
    logic             start_ok;
    logic             pop;
    logic             shift;
    logic             bit_done;
    logic             data_bit;
    logic             par_bit;
    logic [CNT_W-1:0] nbits_in;

    // Gather format inputs and the start condition.
    always_comb begin
        fmt_in.len_code = len_code_i;
        fmt_in.par_en   = par_en_i;
        fmt_in.par_odd  = par_odd_i;
        fmt_in.two_stop = two_stop_i;
        start_ok        = en_i && tx_en_i && !fifo_empty_i;
        nbits_in        = CNT_W'(MIN_BITS) + CNT_W'(len_code_i);
    end

    uart_tx_ctrl #(
        .CNT_W    (CNT_W),
        .MIN_BITS (MIN_BITS)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok_i (start_ok),
        .bit_done_i (bit_done),
        .fmt_i      (fmt_in),
        .state_o    (state),
        .pop_o      (pop),
        .shift_o    (shift)
    );

    uart_tx_tickdiv #(
        .OVS (OVS)
    ) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (pop),
        .tick_i     (tick_i),
        .bit_done_o (bit_done)
    );

    uart_tx_shifter #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (pop),
        .data_i    (fifo_data_i),
        .nbits_i   (nbits_in),
        .par_odd_i (par_odd_i),
        .shift_i   (shift),
        .lsb_o     (data_bit),
        .parity_o  (par_bit)
    );

    // Line level per frame state; idle and stop bits are high.
    always_comb begin
        case (state)
            ST_START:  line_o = 1'b0;
            ST_DATA:   line_o = data_bit;
            ST_PARITY: line_o = par_bit;
            default:   line_o = 1'b1;
        endcase
        busy_o     = (state != ST_IDLE);
        fifo_pop_o = pop;
    end

endmodule

// File: rtl/uart_frame_tx_chk.sv
// Protocol checker for the frame transmitter, bound to every instance.
module uart_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic tx_en_i,
    input logic tick_i,
    input logic fifo_empty_i,
    input logic fifo_pop_o,
    input logic line_o,
    input logic busy_o
);
    p_pop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> (!busy_o && !fifo_empty_i));

    p_pop_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |=> !fifo_pop_o);

    p_pop_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> (en_i && tx_en_i));

    p_start_after_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |=> (busy_o && !line_o));

    p_busy_needs_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !fifo_pop_o) |=> !busy_o);

    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> line_o);

    p_line_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i) |=> $stable(line_o));

    p_ends_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(line_o));
endmodule

bind uart_frame_tx uart_frame_tx_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .tx_en_i      (tx_en_i),
    .tick_i       (tick_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_pop_o   (fifo_pop_o),
    .line_o       (line_o),
    .busy_o       (busy_o)
);

// File: tb/uart_frame_tx_tb_top.sv
// Self-checking bench: sweeps every frame format and reconstructs frames from
// the line by sampling at bit centres.
module uart_frame_tx_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       tx_en = 1'b1;
    logic [1:0] len_code = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       tick = 1'b0;
    logic       pop;
    logic       line;
    logic       busy;

    logic [7:0] mem [0:255];
    logic [7:0] wr_ptr = 8'd0;
    logic [7:0] rd_ptr = 8'd0;
    logic       empty;
    int         pop_count = 0;
    int         cyc = 0;
    int         tp = 1;
    int         tick_cnt = 0;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_P/2) clk = ~clk;

    assign empty = (wr_ptr == rd_ptr);

    uart_frame_tx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .tx_en_i      (tx_en),
        .len_code_i   (len_code),
        .par_en_i     (par_en),
        .par_odd_i    (par_odd),
        .two_stop_i   (two_stop),
        .tick_i       (tick),
        .fifo_empty_i (empty),
        .fifo_data_i  (mem[rd_ptr]),
        .fifo_pop_o   (pop),
        .line_o       (line),
        .busy_o       (busy)
    );

    // FIFO model, cycle counter and baud tick generator.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pop) begin
            rd_ptr    <= rd_ptr + 8'd1;
            pop_count <= pop_count + 1;
        end
        if (tick_cnt >= tp - 1) begin
            tick_cnt <= 0;
            tick     <= 1'b1;
        end else begin
            tick_cnt <= tick_cnt + 1;
            tick     <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        mem[wr_ptr] = d;
        wr_ptr = wr_ptr + 8'd1;
    endtask

    // Waits for a start bit, then samples every bit at its centre.
    task automatic expect_frame(input logic [7:0] d, input int ln, input bit pe,
                                input bit po, input bit ts, output int fall_cyc);
        int nb;
        int waitc;
        logic [7:0] mask;
        logic [7:0] got;
        nb    = 5 + ln;
        mask  = 8'((1 << nb) - 1);
        got   = 8'd0;
        waitc = 0;
        while (line === 1'b1 && waitc < 5000) begin
            @(negedge clk);
            waitc++;
        end
        fall_cyc = cyc;
        chk(waitc < 5000, "R1 start bit seen", waitc, 0);
        repeat (8 * tp) @(negedge clk);
        chk(line === 1'b0, "R1 start level", int'(line), 0);
        chk(busy === 1'b1, "R11 busy in frame", int'(busy), 1);
        for (int i = 0; i < nb; i++) begin
            repeat (16 * tp) @(negedge clk);
            got[i] = line;
        end
        chk(got == (d & mask), "R1/R2 data bits", int'(got), int'(d & mask));
        if (pe) begin
            repeat (16 * tp) @(negedge clk);
            chk(line === ((^(d & mask)) ^ po), "R3/R4 parity bit", int'(line),
                int'((^(d & mask)) ^ po));
        end
        for (int s = 0; s < (ts ? 2 : 1); s++) begin
            repeat (16 * tp) @(negedge clk);
            chk(line === 1'b1, "R5 stop bit", int'(line), 1);
        end
    endtask

    task automatic wait_idle();
        int w;
        w = 0;
        while (busy !== 1'b0 && w < 1000) begin
            @(negedge clk);
            w++;
        end
    endtask

    // Watchdog: a hung run still reaches the summary line.
    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int f1;
        int f2;
        int pc0;
        int nbits_total;
        logic [7:0] d0;
        logic [7:0] d1;

        repeat (3) @(negedge clk);
        chk(line === 1'b1, "R7 reset line", int'(line), 1);
        chk(busy === 1'b0, "R7 reset busy", int'(busy), 0);
        chk(pop === 1'b0, "R7 reset pop", int'(pop), 0);
        rst_n = 1'b1;

        // R7: idle with empty FIFO
        repeat (40) @(negedge clk);
        chk(line === 1'b1 && busy === 1'b0, "R7 idle line high", int'(line), 1);
        chk(pop_count == 0, "R7 no pop when empty", pop_count, 0);

        // Sweep every format with two back-to-back characters.
        for (int ln = 0; ln < 4; ln++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int ts = 0; ts < 2; ts++) begin
                    wait_idle();
                    @(negedge clk);
                    len_code = 2'(ln);
                    par_en   = (pm != 0);
                    par_odd  = (pm == 2);
                    two_stop = ts[0];
                    d0  = 8'(ln * 53 + pm * 17 + ts * 91 + 8'hE3);
                    d1  = ~d0;
                    pc0 = pop_count;
                    mem[wr_ptr]         = d0;
                    mem[wr_ptr + 8'd1]  = d1;
                    wr_ptr = wr_ptr + 8'd2;
                    expect_frame(d0, ln, par_en, par_odd, two_stop, f1);
                    expect_frame(d1, ln, par_en, par_odd, two_stop, f2);
                    nbits_total = 1 + 5 + ln + (pm != 0 ? 1 : 0) + 1 + ts;
                    chk(f2 - f1 == 16 * nbits_total + 1, "R6 start-to-start interval",
                        f2 - f1, 16 * nbits_total + 1);
                    wait_idle();
                    chk(pop_count - pc0 == 2, "R8 one pop per character",
                        pop_count - pc0, 2);
                end
            end
        end

        // R6: slower tick, 8 data bits, odd parity, two stops
        wait_idle();
        @(negedge clk);
        tp = 3;
        len_code = 2'd3; par_en = 1'b1; par_odd = 1'b1; two_stop = 1'b1;
        push(8'h96);
        expect_frame(8'h96, 3, 1'b1, 1'b1, 1'b1, f1);
        wait_idle();
        tp = 1;

        // R9: clear transmit enable mid-frame, then the global enable
        for (int which = 0; which < 2; which++) begin
            wait_idle();
            @(negedge clk);
            len_code = 2'd3; par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
            pc0 = pop_count;
            push(8'h5A);
            push(8'hC3);
            fork
                expect_frame(8'h5A, 3, 1'b0, 1'b0, 1'b0, f1);
                begin
                    repeat (40) @(negedge clk);
                    if (which == 0) tx_en = 1'b0;
                    else en = 1'b0;
                end
            join
            repeat (100) @(negedge clk);
            chk(pop_count - pc0 == 1, "R9 no pop while disabled", pop_count - pc0, 1);
            chk(line === 1'b1 && busy === 1'b0, "R9 line rests high", int'(line), 1);
            tx_en = 1'b1;
            en    = 1'b1;
            expect_frame(8'hC3, 3, 1'b0, 1'b0, 1'b0, f1);
            wait_idle();
        end

        // R10: format changes mid-frame are ignored
        wait_idle();
        @(negedge clk);
        len_code = 2'd1; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1;
        push(8'hFF);
        fork
            expect_frame(8'hFF, 1, 1'b1, 1'b0, 1'b1, f1);
            begin
                repeat (30) @(negedge clk);
                len_code = 2'd3; par_en = 1'b0; par_odd = 1'b1; two_stop = 1'b0;
            end
        join
        wait_idle();
        repeat (20) @(negedge clk);
        chk(line === 1'b1 && busy === 1'b0, "R10 frame closed on latched format",
            int'(busy), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule